// File: doc/BRIEF.md
# Transverse Energy Vector Summer

The block turns a stream of jet-element energies into three event sums: the scalar transverse energy and its x and y components. Each element arrives with an azimuthal bin index. The block multiplies the element's energy by fixed-point cosine and sine constants for that bin and rounds the products to whole energy units. It then accumulates the energy and both products over all elements of an event.

Elements arrive one per clock, framed by a start flag and an end flag. When an event closes, each sum is saturated and compressed into a quad-linear word: a 2-bit range and a 10-bit mantissa. The signed components also carry a sign bit. An even-parity bit is appended to each word, and the three words are presented together with a one-cycle valid strobe for a downstream merger.

Framing is handled by a two-state controller. `ACC_IDLE` means no event is open and `ACC_OPEN` means an event is collecting. Its transitions are:
- **start**: IDLE to OPEN on a start element without the end flag.
- **single**: IDLE to IDLE on an element carrying both flags, which emits a result.
- **restart**: OPEN to OPEN on a start element without the end flag, which discards the partial sums.
- **close**: OPEN to IDLE on any end element, which emits a result.
- **stray**: IDLE to IDLE on an element without the start flag, which is dropped.

Top module: `et_vector_summer`

## Requirements
- R1: The cosine and sine constants are signed 10-bit values in units of 1/256, fixed per bin. Cosine by bin 0 to 7 is 237, 98, -98, -237, -237, -98, 98, 237. Sine of bin b equals cosine of bin (b-2) mod 8. Each product contributes floor((E*C + 128) / 256).
- R2: An event's scalar sum is the plain sum of its element energies, and its x and y sums are the sums of the rounded cosine and sine contributions.
- R3: `in_first` opens an event and `in_last` closes it. A single element with both flags set is a complete event.
- R4: An element with `in_first` arriving while an event is open drops the partial sums, and a new event starts from that element.
- R5: A valid element without `in_first` while no event is open is ignored. It produces no output strobe and does not change the next event's sums.
- R6: Cycles with `in_valid` low inside an open event contribute nothing, whatever the other inputs carry.
- R7: The encoded magnitude is {range[1:0], mantissa[9:0]}. The block picks the smallest range r in 0..3 with magnitude < 1024*4^r, and the mantissa is floor(magnitude / 4^r).
- R8: A magnitude of 65536 or more saturates to range 3 with mantissa 1023 (0xFFF).
- R9: The x and y words are 13 bits: bit 12 is the sign (1 for negative, 0 for zero) and bits 11:0 encode the absolute value. A negative overflow saturates to 0x1FFF.
- R10: Each parity bit makes the count of ones in its word plus the parity bit even.
- R11: `out_valid` is a one-cycle pulse that follows the fourth rising edge, counting the edge that captures the closing element. Events may close on consecutive clocks, and each one yields its own pulse.
- R12: The outputs hold their last values between pulses. Synchronous reset clears all outputs to zero and returns the controller to `ACC_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element present this cycle |
| in_first | input | 1 | Element opens an event |
| in_last | input | 1 | Element closes an event |
| in_et | input | 10 | Element transverse energy, unsigned |
| in_phi | input | 3 | Azimuthal bin index |
| out_valid | output | 1 | New sums presented |
| out_et | output | 12 | Encoded scalar sum |
| out_et_par | output | 1 | Even parity of out_et |
| out_ex | output | 13 | Sign and encoded x sum |
| out_ex_par | output | 1 | Even parity of out_ex |
| out_ey | output | 13 | Sign and encoded y sum |
| out_ey_par | output | 1 | Even parity of out_ey |

## Verification
A framing controller stuck in the wrong state shows up in one of two ways: a stray element is absorbed into the next event's sums, or a restart fails to clear them. Either error is visible on the first strobe after the faulty element, four edges after the closing element. A bad coefficient, rounding offset or range choice corrupts the word of that same strobe. A misaligned valid pipeline moves the strobe off its slot on every event. The bench model compares the strobe, all three words and their parity on every clock, so any of these faults is caught at the first affected event.

// File: rtl/etv_pkg.sv
package etv_pkg;

    localparam int COEF_W     = 10;
    localparam int FRAC_W     = 8;
    localparam int PHI_W      = 3;
    localparam int RANGE_W    = 2;
    localparam int MANT_W     = 10;
    localparam int RSTEP      = 2;
    localparam int NUM_RANGES = 1 << RANGE_W;
    localparam int CODE_W     = RANGE_W + MANT_W;

    localparam logic signed [COEF_W-1:0] TRIG_NEAR = 10'sd237;
    localparam logic signed [COEF_W-1:0] TRIG_FAR  = 10'sd98;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_OPEN = 1'b1
    } acc_state_t;

    // Sine of a bin is the cosine of the bin two places earlier.
    function automatic logic signed [COEF_W-1:0] trig_coef(
        input logic [PHI_W-1:0] bin,
        input logic             y_axis
    );
        logic [PHI_W-1:0] idx;
        idx = y_axis ? bin - PHI_W'(2) : bin;
        unique case (idx)
            3'd0, 3'd7: trig_coef = TRIG_NEAR;
            3'd1, 3'd6: trig_coef = TRIG_FAR;
            3'd2, 3'd5: trig_coef = -TRIG_FAR;
            default:    trig_coef = -TRIG_NEAR;
        endcase
    endfunction

endpackage

// File: rtl/etv_mult_stage.sv
module etv_mult_stage
    import etv_pkg::*;
#(
    parameter int ET_W   = 10,
    parameter int PROD_W = ET_W + COEF_W + 1 - FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic                     in_last,
    input  logic [ET_W-1:0]          in_et,
    input  logic [PHI_W-1:0]         in_phi,
    output logic                     s1_valid,
    output logic                     s1_first,
    output logic                     s1_last,
    output logic [ET_W-1:0]          s1_et,
    output logic signed [PROD_W-1:0] s1_ex,
    output logic signed [PROD_W-1:0] s1_ey
);

    localparam int MUL_W = ET_W + COEF_W + 1;
    localparam logic signed [MUL_W-1:0] HALF = MUL_W'(1) << (FRAC_W - 1);

    logic signed [PROD_W-1:0] prod_w [2];

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        logic signed [COEF_W-1:0] coef;
        logic signed [MUL_W-1:0]  prod;
        assign coef       = trig_coef(in_phi, 1'(ax));
        assign prod       = $signed({1'b0, in_et}) * coef;
        assign prod_w[ax] = PROD_W'((prod + HALF) >>> FRAC_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_et    <= '0;
            s1_ex    <= '0;
            s1_ey    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_first <= in_first;
            s1_last  <= in_last;
            s1_et    <= in_et;
            s1_ex    <= prod_w[0];
            s1_ey    <= prod_w[1];
        end
    end

endmodule

// File: rtl/etv_accum.sv
module etv_accum
    import etv_pkg::*;
#(
    parameter int ET_W   = 10,
    parameter int PROD_W = 13,
    parameter int ACC_W  = 21
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s1_valid,
    input  logic                     s1_first,
    input  logic                     s1_last,
    input  logic [ET_W-1:0]          s1_et,
    input  logic signed [PROD_W-1:0] s1_ex,
    input  logic signed [PROD_W-1:0] s1_ey,
    output logic                     sum_valid,
    output logic [ACC_W-1:0]         sum_et,
    output logic [ACC_W-1:0]         sum_ex,
    output logic [ACC_W-1:0]         sum_ey
);

    acc_state_t state, state_nx;

    logic             take;
    logic [ACC_W-1:0] acc_et, acc_ex, acc_ey;
    logic [ACC_W-1:0] new_et, new_ex, new_ey;

    assign take = s1_valid && (s1_first || state == ACC_OPEN);

    always_comb begin
        new_et = (s1_first ? '0 : acc_et) + {{(ACC_W-ET_W){1'b0}}, s1_et};
        new_ex = (s1_first ? '0 : acc_ex) + {{(ACC_W-PROD_W){s1_ex[PROD_W-1]}}, s1_ex};
        new_ey = (s1_first ? '0 : acc_ey) + {{(ACC_W-PROD_W){s1_ey[PROD_W-1]}}, s1_ey};
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_IDLE: if (s1_valid && s1_first && !s1_last) state_nx = ACC_OPEN;
            ACC_OPEN: if (s1_valid && s1_last)              state_nx = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ACC_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_et    <= '0;
            acc_ex    <= '0;
            acc_ey    <= '0;
            sum_valid <= 1'b0;
            sum_et    <= '0;
            sum_ex    <= '0;
            sum_ey    <= '0;
        end else begin
            sum_valid <= take && s1_last;
            if (take) begin
                acc_et <= new_et;
                acc_ex <= new_ex;
                acc_ey <= new_ey;
            end
            if (take && s1_last) begin
                sum_et <= new_et;
                sum_ex <= new_ex;
                sum_ey <= new_ey;
            end
        end
    end

endmodule

// File: rtl/etv_qlin_encoder.sv
module etv_qlin_encoder
    import etv_pkg::*;
#(
    parameter int ACC_W  = 21,
    parameter int SIGN_W = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ACC_W-1:0]         in_sum,
    output logic [CODE_W+SIGN_W-1:0] out_word,
    output logic                     out_par
);

    localparam int WORD_W = CODE_W + SIGN_W;

    logic [ACC_W-1:0]   mag;
    logic [RANGE_W-1:0] rng;
    logic [MANT_W-1:0]  mant;
    logic [CODE_W-1:0]  code_q;
    logic [WORD_W-1:0]  word_nx;

    // Scan from the widest range down so the narrowest fitting range wins.
    always_comb begin
        rng  = RANGE_W'(NUM_RANGES - 1);
        mant = '1;
        for (int r = NUM_RANGES - 1; r >= 0; r--) begin
            if (mag < (ACC_W'(1) << (MANT_W + RSTEP * r))) begin
                rng  = RANGE_W'(r);
                mant = MANT_W'(mag >> (RSTEP * r));
            end
        end
    end

    if (SIGN_W > 0) begin : g_signed
        logic neg, sign_q;
        assign neg     = in_sum[ACC_W-1];
        assign mag     = neg ? (~in_sum + 1'b1) : in_sum;
        assign word_nx = {sign_q, code_q};
        always_ff @(posedge clk) begin
            if (rst) sign_q <= 1'b0;
            else     sign_q <= neg;
        end
    end else begin : g_unsigned
        assign mag     = in_sum;
        assign word_nx = code_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            out_word <= '0;
            out_par  <= 1'b0;
        end else begin
            code_q   <= {rng, mant};
            out_word <= word_nx;
            out_par  <= ^word_nx;
        end
    end

endmodule

// File: rtl/et_vector_summer.sv
module et_vector_summer
    import etv_pkg::*;
#(
    parameter int ET_W     = 10,
    parameter int MAX_ELEM = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [ET_W-1:0]   in_et,
    input  logic [PHI_W-1:0]  in_phi,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_et,
    output logic              out_et_par,
    output logic [CODE_W:0]   out_ex,
    output logic              out_ex_par,
    output logic [CODE_W:0]   out_ey,
    output logic              out_ey_par
);

    localparam int PROD_W = ET_W + COEF_W + 1 - FRAC_W;
    localparam int ACC_W  = PROD_W + $clog2(MAX_ELEM) + 1;

    logic                     s1_valid, s1_first, s1_last;
    logic [ET_W-1:0]          s1_et;
    logic signed [PROD_W-1:0] s1_ex, s1_ey;
    logic                     sum_valid, v_enc;
    logic [ACC_W-1:0]         sum_et, sum_ex, sum_ey;

    etv_mult_stage #(.ET_W(ET_W), .PROD_W(PROD_W)) u_mult (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_et(in_et), .in_phi(in_phi),
        .s1_valid(s1_valid), .s1_first(s1_first), .s1_last(s1_last),
        .s1_et(s1_et), .s1_ex(s1_ex), .s1_ey(s1_ey)
    );

    etv_accum #(.ET_W(ET_W), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst),
        .s1_valid(s1_valid), .s1_first(s1_first), .s1_last(s1_last),
        .s1_et(s1_et), .s1_ex(s1_ex), .s1_ey(s1_ey),
        .sum_valid(sum_valid), .sum_et(sum_et), .sum_ex(sum_ex), .sum_ey(sum_ey)
    );

    etv_qlin_encoder #(.ACC_W(ACC_W), .SIGN_W(0)) u_enc_et (
        .clk(clk), .rst(rst), .in_sum(sum_et), .out_word(out_et), .out_par(out_et_par)
    );

    etv_qlin_encoder #(.ACC_W(ACC_W), .SIGN_W(1)) u_enc_ex (
        .clk(clk), .rst(rst), .in_sum(sum_ex), .out_word(out_ex), .out_par(out_ex_par)
    );

    etv_qlin_encoder #(.ACC_W(ACC_W), .SIGN_W(1)) u_enc_ey (
        .clk(clk), .rst(rst), .in_sum(sum_ey), .out_word(out_ey), .out_par(out_ey_par)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_enc     <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_enc     <= sum_valid;
            out_valid <= v_enc;
        end
    end

endmodule

// File: rtl/etv_summer_checker.sv
module etv_summer_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_last,
    input logic        out_valid,
    input logic [11:0] out_et,
    input logic        out_et_par,
    input logic [12:0] out_ex,
    input logic        out_ex_par,
    input logic [12:0] out_ey,
    input logic        out_ey_par
);

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_last, 4));

    p_even_parity_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!(^{out_et, out_et_par}) && !(^{out_ex, out_ex_par})
                       && !(^{out_ey, out_ey_par})));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_et) && $stable(out_ex) && $stable(out_ey)));

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (!out_valid && out_et == 12'd0 && out_ex == 13'd0 && out_ey == 13'd0));

    p_min_range_et_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_et[11:10] != 2'd0) |-> (out_et[9:8] != 2'd0));

    p_min_range_ex_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ex[11:10] != 2'd0) |-> (out_ex[9:8] != 2'd0));

    p_min_range_ey_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ey[11:10] != 2'd0) |-> (out_ey[9:8] != 2'd0));

    p_zero_sign_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_ex[11:0] != 12'd0 || !out_ex[12])
                       && (out_ey[11:0] != 12'd0 || !out_ey[12])));

endmodule

bind et_vector_summer etv_summer_checker u_chk (.*);

// File: tb/et_vector_summer_tb_top.sv
`timescale 1ns/100ps
module et_vector_summer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [9:0]  in_et = '0;
    logic [2:0]  in_phi = '0;
    logic        out_valid, out_et_par, out_ex_par, out_ey_par;
    logic [11:0] out_et;
    logic [12:0] out_ex, out_ey;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    et_vector_summer dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_et(in_et), .in_phi(in_phi),
        .out_valid(out_valid),
        .out_et(out_et), .out_et_par(out_et_par),
        .out_ex(out_ex), .out_ex_par(out_ex_par),
        .out_ey(out_ey), .out_ey_par(out_ey_par)
    );

    // ---------------- reference model ----------------
    function automatic int cos_ref(input int bin);
        int tbl [8] = '{237, 98, -98, -237, -237, -98, 98, 237};
        return tbl[bin & 7];
    endfunction

    function automatic int contrib(input int e, input int c);
        return (e * c + 128) >>> 8;
    endfunction

    function automatic logic [11:0] enc_u(input longint m);
        int r = 0;
        if (m > 65535) return 12'hFFF;
        while (m >= (longint'(1024) << (2 * r))) r++;
        return {2'(r), 10'(m >> (2 * r))};
    endfunction

    function automatic logic [12:0] enc_s(input longint v);
        if (v < 0) return {1'b1, enc_u(-v)};
        return {1'b0, enc_u(v)};
    endfunction

    bit          m_open;
    longint      m_et, m_ex, m_ey;
    bit          qv  [4];
    logic [11:0] qet [4];
    logic [12:0] qex [4], qey [4];
    logic [11:0] h_et;
    logic [12:0] h_ex, h_ey;

    always @(posedge clk) begin
        if (rst) begin
            m_open = 0; m_et = 0; m_ex = 0; m_ey = 0;
            for (int i = 0; i < 4; i++) begin
                qv[i] = 0; qet[i] = '0; qex[i] = '0; qey[i] = '0;
            end
            h_et = '0; h_ex = '0; h_ey = '0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                qv[i] = qv[i-1]; qet[i] = qet[i-1]; qex[i] = qex[i-1]; qey[i] = qey[i-1];
            end
            qv[0] = 0;
            if (in_valid && (in_first || m_open)) begin
                if (in_first) begin m_et = 0; m_ex = 0; m_ey = 0; end
                m_et += int'(in_et);
                m_ex += contrib(int'(in_et), cos_ref(int'(in_phi)));
                m_ey += contrib(int'(in_et), cos_ref(int'(in_phi) + 6));
                if (in_last) begin
                    m_open = 0;
                    qv[0] = 1; qet[0] = enc_u(m_et); qex[0] = enc_s(m_ex); qey[0] = enc_s(m_ey);
                end else begin
                    m_open = 1;
                end
            end
            if (qv[3]) begin h_et = qet[3]; h_ex = qex[3]; h_ey = qey[3]; end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(32'(out_valid), 32'(qv[3]), "R11 out_valid strobe");
            chk(32'(out_et), 32'(h_et), "R2/R7/R8/R12 out_et");
            chk(32'(out_ex), 32'(h_ex), "R1/R2/R9 out_ex");
            chk(32'(out_ey), 32'(h_ey), "R1/R2/R9 out_ey");
            chk(32'({out_et_par, out_ex_par, out_ey_par}),
                32'({^h_et, ^h_ex, ^h_ey}), "R10 parity");
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit v, input bit f, input bit l, input int e, input int p);
        @(negedge clk);
        in_valid = v; in_first = f; in_last = l; in_et = 10'(e); in_phi = 3'(p);
    endtask

    task automatic idle(input int n);
        repeat (n) drive(0, 0, 0, 0, 0);
    endtask

    task automatic settle();
        idle(1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(32'({out_valid, out_et, out_ex, out_ey}), 32'd0, "R12 reset state");
        rst = 1'b0;
        idle(2);

        // R3: single-element event, bin 2
        drive(1, 1, 1, 100, 2);
        settle();
        chk(32'(out_valid), 32'd1, "R3 single-element strobe");
        chk(32'(out_ex), 32'h1026, "R1 x contribution bin 2");
        chk(32'(out_ey), 32'h005D, "R1 y contribution bin 2");
        chk(32'(out_ex_par), 32'd0, "R10 x parity");

        // R7: boundary 1024 lands in range 1
        drive(1, 1, 0, 1023, 0);
        drive(1, 0, 1, 1, 0);
        settle();
        chk(32'(out_et), 32'h500, "R7 Et=1024 range 1");

        // R6: gap cycle with junk data inside event
        drive(1, 1, 0, 10, 1);
        drive(0, 0, 0, 999, 5);
        drive(0, 1, 1, 999, 5);
        drive(1, 0, 1, 30, 1);
        settle();
        chk(32'(out_et), 32'h028, "R6 gap cycles ignored");

        // R5: stray element while idle
        drive(1, 0, 1, 900, 3);
        idle(6);
        drive(1, 1, 1, 5, 3);
        settle();
        chk(32'(out_et), 32'h005, "R5 stray element ignored");

        // R4: restart drops partial sums
        drive(1, 1, 0, 500, 0);
        drive(1, 1, 1, 7, 0);
        settle();
        chk(32'(out_et), 32'h007, "R4 restart clears partial");

        // R8 / R9: positive and negative saturation
        for (int i = 0; i < 70; i++) drive(1, i == 0, i == 69, 1023, 4);
        settle();
        chk(32'(out_et), 32'hFFF, "R8 Et saturation");
        chk(32'(out_ex), 32'h1FFF, "R9 negative x saturation");

        // R11: events closing on consecutive clocks
        for (int i = 0; i < 8; i++) drive(1, 1, 1, 64 * i + 3, i);
        idle(6);

        // mixed traffic checked by the model
        for (int ev = 0; ev < 60; ev++) begin
            int len = 1 + int'($urandom_range(0, 5));
            if ($urandom_range(0, 7) == 0) drive(1, 0, 0, int'($urandom_range(0, 1023)), 0);
            for (int k = 0; k < len; k++) begin
                if ($urandom_range(0, 3) == 0) drive(0, 1, 1, 777, 1);
                drive(1, k == 0, k == len - 1,
                      int'($urandom_range(0, 1023)), int'($urandom_range(0, 7)));
            end
            if ($urandom_range(0, 1) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule